// File: doc/BRIEF.md
# Echo-Verified Pulse Stretcher for an Isolated Open-Drain Line

This controller sits on the weak-low side of one bidirectional channel of an isolated open-drain bus. It receives two level signals. One reports that an external device holds the local line low; short glitches have already been removed from it. The other reports that the far side of the barrier is low, as carried by the return channel. The controller drives two outputs. One is a request into the outbound channel toward the far side. The other is a self-drive enable that pulls the local line to a weak low level. That weak level sits above the local receive threshold, so the block never sees its own drive as an input.

A low that starts locally sets a remembered flag. The outbound request stays asserted, even after the local device lets go, until the far side echoes the low back on the return channel. This verification loop makes the outbound pulse at least one round trip long, and its length follows the real channel delays. The result is one edge pair on each side for every accepted pulse, with no echo double pulse. The local line is held at the weak low until the far side releases. A low that starts on the far side only causes local self-drive for as long as it lasts.

Both inputs are asynchronous to the clock. Each passes through a synchronizer of `SYNC_STAGES` flops (at least 1). All control pins are plain levels, with no handshake.

Top module: `pulse_stretch_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the flag and the synchronizers, and both outputs are 0 in the cycle after reset.
- R2: Each input reaches the logic after `SYNC_STAGES` clock edges, so `fwd_req_o` rises `SYNC_STAGES` cycles after `loc_low_i` rises, when nothing else holds it.
- R3: A rising edge of the synchronized local-low level while the synchronized return level is 0 sets the flag one cycle later. While the flag is set, `fwd_req_o` stays 1 even after `loc_low_i` returns to 0.
- R4: While the flag is set, `self_drv_o` is 1.
- R5: A rising edge of the synchronized return level clears the flag one cycle later. From then on `fwd_req_o` follows the synchronized local-low level alone.
- R6: `self_drv_o` stays 1 while the synchronized return level is 1, and drops once that level and the flag are both 0.
- R7: When the return level rises while the flag is clear, the flag stays clear. `self_drv_o` follows the synchronized return level, and `fwd_req_o` stays 0 unless the local level is 1.
- R8: A rising local level while the synchronized return level is 1 does not set the flag. `fwd_req_o` then equals the local level, and `self_drv_o` falls as soon as the return falls.
- R9: In a closed loop where the return channel echoes `fwd_req_o` after a delay, every accepted local pulse of any width gives exactly one rising edge on `fwd_req_o` and exactly one on `self_drv_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| loc_low_i | input | 1 | Filtered local line-low indication from external devices (1 = low) |
| ret_low_i | input | 1 | Return channel from the far side (1 = far side low) |
| fwd_req_o | output | 1 | Request into the outbound channel (1 = assert low at the far side) |
| self_drv_o | output | 1 | Enable for the weak-low self-drive of the local line |

## Verification
The embedded assertions check the flag's state changes on every cycle. These are: the set on a local rising edge with the return idle, holding until an echo arrives, the clear on a return rising edge, no set while the far side originates, and both outputs asserted when the flag rises. The whole loop can only be shown by the bench scenarios. That covers pulse stretching until the echo, equal edge counts across several pulse widths and echo delays, far-originated lows, and the synchronizer latency. The bench's reference model is compared on every clock.

// File: rtl/iso_stretch_pkg.sv
package iso_stretch_pkg;

  // Synchronized view of one input line: its level and a one-cycle
  // pulse on its rising edge.
  typedef struct packed {
    logic level;
    logic rise;
  } line_view_t;

endpackage

// File: rtl/iso_sync_chain.sv
module iso_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr[STAGES-1];

endmodule

// File: rtl/iso_edge_view.sv
module iso_edge_view
  import iso_stretch_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lvl_i,
  output line_view_t view_o
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl_i;
  end

  assign view_o.level = lvl_i;
  assign view_o.rise  = lvl_i & ~prev_q;

endmodule

// File: rtl/iso_echo_flag.sv
module iso_echo_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;

  // Clear has priority: an echo always ends the stretched request.
  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (clr_i) flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/pulse_stretch_ctrl.sv
module pulse_stretch_ctrl
  import iso_stretch_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic loc_low_i,
  input  logic ret_low_i,
  output logic fwd_req_o,
  output logic self_drv_o
);

  logic       loc_sync;
  logic       ret_sync;
  line_view_t loc_v;
  line_view_t ret_v;
  logic       set_ev;
  logic       clr_ev;
  logic       held;

  iso_sync_chain #(.STAGES(SYNC_STAGES)) u_loc_sync (
    .clk(clk), .rst(rst), .d_i(loc_low_i), .q_o(loc_sync)
  );

  iso_sync_chain #(.STAGES(SYNC_STAGES)) u_ret_sync (
    .clk(clk), .rst(rst), .d_i(ret_low_i), .q_o(ret_sync)
  );

  iso_edge_view u_loc_edge (
    .clk(clk), .rst(rst), .lvl_i(loc_sync), .view_o(loc_v)
  );

  iso_edge_view u_ret_edge (
    .clk(clk), .rst(rst), .lvl_i(ret_sync), .view_o(ret_v)
  );

  // Only a locally originated low is remembered; while the far side
  // already reports low, the request simply mirrors the local level.
  assign set_ev = loc_v.rise & ~ret_v.level;
  assign clr_ev = ret_v.rise;

  iso_echo_flag u_flag (
    .clk(clk), .rst(rst), .set_i(set_ev), .clr_i(clr_ev), .flag_o(held)
  );

  assign fwd_req_o  = loc_v.level | held;
  assign self_drv_o = held | ret_v.level;

  // R1: outputs idle right after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!fwd_req_o && !self_drv_o));

  // R3: local rising edge with an idle return sets the flag
  p_set_on_local_r3: assert property (@(posedge clk) disable iff (rst)
    (loc_v.rise && !ret_v.level) |=> held);

  // R3: flag persists until an echo edge arrives
  p_hold_until_echo_r3: assert property (@(posedge clk) disable iff (rst)
    (held && !ret_v.rise) |=> held);

  // R4: both outputs asserted when the flag rises
  p_outputs_on_set_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(held) |-> (fwd_req_o && self_drv_o));

  // R5: echo edge clears the flag
  p_clear_on_echo_r5: assert property (@(posedge clk) disable iff (rst)
    ret_v.rise |=> !held);

  // R7: far-originated low never sets the flag
  p_no_set_far_r7: assert property (@(posedge clk) disable iff (rst)
    (!held && ret_v.level) |=> !held);

endmodule

// File: tb/pulse_stretch_ctrl_tb_top.sv
module pulse_stretch_ctrl_tb_top;

  localparam int NS = 2;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic loc_low_i = 1'b0;
  logic ret_low_i = 1'b0;
  logic fwd_req_o, self_drv_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  // reference model state
  logic [NS-1:0] m_lsr = '0, m_rsr = '0;
  logic m_lprev = 0, m_rprev = 0, m_flag = 0;

  always #4 clk = ~clk;

  pulse_stretch_ctrl #(.SYNC_STAGES(NS)) dut_i (
    .clk(clk), .rst(rst), .loc_low_i(loc_low_i), .ret_low_i(ret_low_i),
    .fwd_req_o(fwd_req_o), .self_drv_o(self_drv_o)
  );

  task automatic chk(input logic got, input logic exp, input string tag,
                     input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual=%b expected=%b",
               tag, what, cyc, got, exp);
    end
  endtask

  task automatic model_adv(input logic l, input logic r, input logic rs);
    logic ls, rsy, nf;
    if (rs) begin
      m_lsr = '0; m_rsr = '0; m_lprev = 0; m_rprev = 0; m_flag = 0;
    end else begin
      ls  = m_lsr[NS-1];
      rsy = m_rsr[NS-1];
      nf  = m_flag;
      if (rsy && !m_rprev)           nf = 1'b0;
      else if (ls && !m_lprev && !rsy) nf = 1'b1;
      m_lprev = ls;
      m_rprev = rsy;
      for (int k = NS-1; k > 0; k--) begin
        m_lsr[k] = m_lsr[k-1];
        m_rsr[k] = m_rsr[k-1];
      end
      m_lsr[0] = l;
      m_rsr[0] = r;
      m_flag = nf;
    end
  endtask

  // One clock: apply inputs, wait past the edge, advance model, compare.
  task automatic step(input logic l, input logic r, input logic rs,
                      input string tag);
    loc_low_i = l;
    ret_low_i = r;
    rst = rs;
    @(posedge clk);
    #2;
    cyc++;
    model_adv(l, r, rs);
    chk(fwd_req_o,  m_lsr[NS-1] | m_flag, tag, "fwd_req_o");
    chk(self_drv_o, m_flag | m_rsr[NS-1], tag, "self_drv_o");
  endtask

  // Closed loop: return echoes fwd_req_o after dly cycles (R9).
  task automatic loop_pulse(input int width, input int dly);
    logic hist[$];
    logic pf, pd, r;
    int fr, dr;
    pf = 0; pd = 0; fr = 0; dr = 0;
    for (int c = 0; c < 70; c++) begin
      r = (hist.size() >= dly) ? hist[hist.size()-dly] : 1'b0;
      step(c < width, r, 1'b0, "R9");
      if (fwd_req_o && !pf) fr++;
      if (self_drv_o && !pd) dr++;
      pf = fwd_req_o;
      pd = self_drv_o;
      hist.push_back(fwd_req_o);
    end
    chk(fr == 1, 1'b1, "R9", $sformatf("fwd rises=%0d (w=%0d d=%0d)", fr, width, dly));
    chk(dr == 1, 1'b1, "R9", $sformatf("drv rises=%0d (w=%0d d=%0d)", dr, width, dly));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    for (int w = 0; w < WATCHDOG; w++) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R9 watchdog: actual=hung expected=complete");
    finish_run();
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) step(0, 0, 1, "R1");
    chk(fwd_req_o, 1'b0, "R1", "fwd after reset");
    chk(self_drv_o, 1'b0, "R1", "drv after reset");

    // R2: latency of the local path
    step(1, 0, 0, "R2");
    chk(fwd_req_o, 1'b0, "R2", "fwd one edge after input");
    step(1, 0, 0, "R2");
    chk(fwd_req_o, 1'b1, "R2", "fwd after SYNC_STAGES edges");

    // R3/R4: release locally, request and drive held without echo
    for (int i = 0; i < 10; i++) step(0, 0, 0, "R3");
    chk(fwd_req_o, 1'b1, "R3", "fwd held after local release");
    chk(self_drv_o, 1'b1, "R4", "drive held while flag set");

    // R5/R6: echo arrives, request drops, drive held until far release
    for (int i = 0; i < 6; i++) step(0, 1, 0, "R5");
    chk(fwd_req_o, 1'b0, "R5", "fwd cleared by echo");
    chk(self_drv_o, 1'b1, "R6", "drive held during return low");
    for (int i = 0; i < 4; i++) step(0, 0, 0, "R6");
    chk(self_drv_o, 1'b0, "R6", "drive released after return high");

    // R7: far-originated low
    for (int i = 0; i < 6; i++) step(0, 1, 0, "R7");
    chk(self_drv_o, 1'b1, "R7", "drive follows return");
    chk(fwd_req_o, 1'b0, "R7", "no request for far low");
    for (int i = 0; i < 4; i++) step(0, 0, 0, "R7");
    chk(self_drv_o, 1'b0, "R7", "drive ends with return, no flag");

    // R8: local low while far side already low
    for (int i = 0; i < 4; i++) step(0, 1, 0, "R8");
    for (int i = 0; i < 4; i++) step(1, 1, 0, "R8");
    chk(fwd_req_o, 1'b1, "R8", "fwd mirrors local");
    for (int i = 0; i < 4; i++) step(0, 1, 0, "R8");
    chk(fwd_req_o, 1'b0, "R8", "fwd drops with local, no stretch");
    for (int i = 0; i < 4; i++) step(0, 0, 0, "R8");
    chk(self_drv_o, 1'b0, "R8", "drive ends with return");

    // R9: closed loop, several widths and delays
    loop_pulse(1, 3);
    loop_pulse(2, 7);
    loop_pulse(20, 3);
    loop_pulse(5, 1);
    loop_pulse(40, 9);

    // R1: reset in the middle of a stretched pulse
    for (int i = 0; i < 3; i++) step(1, 0, 0, "R3");
    for (int i = 0; i < 3; i++) step(0, 0, 0, "R3");
    step(0, 0, 1, "R1");
    chk(fwd_req_o, 1'b0, "R1", "fwd after mid-pulse reset");
    chk(self_drv_o, 1'b0, "R1", "drv after mid-pulse reset");
    for (int i = 0; i < 4; i++) step(0, 0, 0, "R1");

    finish_run();
  end

endmodule